// File: doc/BRIEF.md
# Three-Bank Interrupt Controller

This block gathers level-sensitive interrupt sources into three groups: a primary group of eight direct lines and two secondary groups of thirty-two lines each. Each group has its own mask, which software changes through write-one-to-set and write-one-to-clear words on a small 32-bit register bus. The primary status word is the one software reads first. It holds the unmasked primary lines, one summary flag per secondary group, and direct copies of a fixed set of secondary sources, called shortcut bits. A handler can often find its source from that single read.

A secondary source that has a shortcut shows up in its shortcut bit and in its own group's status word, but not in the group's summary flag. The summary flags have no mask. Shortcut bits are masked only through their own group's mask. The normal interrupt output is the OR of the primary status word. A routing word selects one raw source from any group and drives the fast interrupt output from it. This path does not depend on the masks, so a routed source that is also unmasked drives both outputs.

Top module: `irqc_tribank`

## Requirements
- R1: After reset every mask word, the fast-route word, every status word and both interrupt outputs read zero.
- R2: A write of 1 to a bit of a group's set word (primary 0x18, group one 0x10, group two 0x14) sets that mask bit. A write of 1 to the matching clear word (0x24, 0x1C, 0x20) clears it. Bits written as 0 stay unchanged, and reading either word returns the mask.
- R3: Status words 0x04 and 0x08 read as the group's raw sources ANDed with its mask.
- R4: Bits 7:0 of the primary status word (0x00) read as the raw primary lines ANDed with the primary mask.
- R5: Primary status bit 8 (group one) or bit 9 (group two) is set exactly when an unmasked source without a shortcut is pending in that group. Shortcut sources never set it.
- R6: Primary status bits 14:10 mirror the masked group-one sources 7, 9, 10, 18, 19 in that order. Bits 20:15 mirror the masked group-two sources 21, 22, 23, 24, 25, 30. Bits 31:21 read zero.
- R7: The primary mask holds only bits 7:0. Writes to higher positions of the primary set or clear words change nothing, and in particular cannot mask or unmask a shortcut bit.
- R8: The interrupt output goes high one clock after any primary status bit is set, including the unmaskable summary bits, and low one clock after all are clear.
- R9: The fast-route word at 0x0C holds a 7-bit index in bits 6:0 and an enable in bit 7, and reads back zero above bit 7. Indices 0–31 select group-one raw sources, 32–63 select group-two raw sources, and 64–71 select primary raw lines. The fast output follows the selected raw source one clock later while enabled, and is low while disabled.
- R10: A source that is both routed to the fast output and unmasked drives both outputs high at once.
- R11: Route indices 72–127 select no source, and the fast output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_prim | input | 8 | Primary group level sources |
| src_grp1 | input | 32 | Group one level sources |
| src_grp2 | input | 32 | Group two level sources |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is telling a shortcut source apart from an ordinary one in the same group. Both look the same in the group's status word, and the difference shows only in which primary bit lights up. The stimulus unmasks a whole group and then drives one source at a time through every shortcut position and one ordinary position. For each, it checks that exactly the expected primary bit is set. It then tries to mask those bits through the primary clear word and confirms they stay set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GRP_W   = 32;
  localparam int PRIM_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int RIDX_W  = 7;
  localparam int ROUTE_N = 2 * GRP_W + PRIM_W;
  localparam int RSPACE  = 1 << RIDX_W;

  typedef enum logic [3:0] {
    RS_STAT0, RS_STAT1, RS_STAT2, RS_ROUTE,
    RS_SET1, RS_SET2, RS_SET0, RS_CLR1, RS_CLR2, RS_CLR0, RS_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      6'h00:   return RS_STAT0;
      6'h04:   return RS_STAT1;
      6'h08:   return RS_STAT2;
      6'h0C:   return RS_ROUTE;
      6'h10:   return RS_SET1;
      6'h14:   return RS_SET2;
      6'h18:   return RS_SET0;
      6'h1C:   return RS_CLR1;
      6'h20:   return RS_CLR2;
      6'h24:   return RS_CLR0;
      default: return RS_NONE;
    endcase
  endfunction

  function automatic int sc1_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int sc2_src(input int k);
    case (k)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [GRP_W-1:0] sc1_set();
    logic [GRP_W-1:0] m;
    m = '0;
    for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_W-1:0] sc2_set();
    logic [GRP_W-1:0] m;
    m = '0;
    for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_d  = mask_q;
    mask_en = set_we | clr_we;
    if (set_we) mask_d = mask_d | wdata;
    if (clr_we) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wdata)) == '0)); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/irqc_shortcut_map.sv
module irqc_shortcut_map
  import irqc_pkg::*;
(
  input  logic [GRP_W-1:0] g1_pend,
  input  logic [GRP_W-1:0] g2_pend,
  output logic [SC1_N-1:0] sc1_bits,
  output logic [SC2_N-1:0] sc2_bits,
  output logic             sum1,
  output logic             sum2
);
  localparam logic [GRP_W-1:0] SC1_SET = sc1_set();
  localparam logic [GRP_W-1:0] SC2_SET = sc2_set();

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign sc1_bits[k] = g1_pend[sc1_src(k)];
  end

  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign sc2_bits[k] = g2_pend[sc2_src(k)];
  end

  assign sum1 = |(g1_pend & ~SC1_SET);
  assign sum2 = |(g2_pend & ~SC2_SET);
endmodule

// File: rtl/irqc_fiq_sel.sv
module irqc_fiq_sel
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        wdata,
  input  logic [PRIM_W-1:0] raw_prim,
  input  logic [GRP_W-1:0]  raw_g1,
  input  logic [GRP_W-1:0]  raw_g2,
  output logic [7:0]        ctrl_q,
  output logic              hit
);
  logic [RSPACE-1:0] route_vec;
  logic [7:0]        ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign route_vec = {{(RSPACE-ROUTE_N){1'b0}}, raw_prim, raw_g2, raw_g1};
  assign hit       = ctrl_q[7] & route_vec[ctrl_q[RIDX_W-1:0]];
endmodule

// File: rtl/irqc_tribank.sv
module irqc_tribank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PRIM_W-1:0] src_prim,
  input  logic [GRP_W-1:0]  src_grp1,
  input  logic [GRP_W-1:0]  src_grp2,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [GRP_W-1:0] SC1_SET = sc1_set();
  localparam int               PAD_W   = 32 - (PRIM_W + 2 + SC1_N + SC2_N);

  logic              rst_ns;
  reg_sel_e          sel;
  logic [PRIM_W-1:0] mask0;
  logic [GRP_W-1:0]  mask1, mask2;
  logic [GRP_W-1:0]  g1_pend, g2_pend;
  logic [SC1_N-1:0]  sc1_bits;
  logic [SC2_N-1:0]  sc2_bits;
  logic              sum1, sum2;
  logic [31:0]       stat0;
  logic [7:0]        route_q;
  logic              fiq_hit;
  logic              irq_d, fiq_d;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign sel = decode(bus_addr);

  irqc_mask_reg #(.W(PRIM_W)) u_mask0 (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_we && sel == RS_SET0), .clr_we(bus_we && sel == RS_CLR0),
    .wdata(bus_wdata[PRIM_W-1:0]), .mask_q(mask0));

  irqc_mask_reg #(.W(GRP_W)) u_mask1 (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_we && sel == RS_SET1), .clr_we(bus_we && sel == RS_CLR1),
    .wdata(bus_wdata[GRP_W-1:0]), .mask_q(mask1));

  irqc_mask_reg #(.W(GRP_W)) u_mask2 (
    .clk(clk), .rst_n(rst_ns),
    .set_we(bus_we && sel == RS_SET2), .clr_we(bus_we && sel == RS_CLR2),
    .wdata(bus_wdata[GRP_W-1:0]), .mask_q(mask2));

  assign g1_pend = src_grp1 & mask1;
  assign g2_pend = src_grp2 & mask2;

  irqc_shortcut_map u_map (
    .g1_pend(g1_pend), .g2_pend(g2_pend),
    .sc1_bits(sc1_bits), .sc2_bits(sc2_bits),
    .sum1(sum1), .sum2(sum2));

  assign stat0 = {{PAD_W{1'b0}}, sc2_bits, sc1_bits, sum2, sum1, src_prim & mask0};

  irqc_fiq_sel u_fiq (
    .clk(clk), .rst_n(rst_ns),
    .ctrl_we(bus_we && sel == RS_ROUTE), .wdata(bus_wdata[7:0]),
    .raw_prim(src_prim), .raw_g1(src_grp1), .raw_g2(src_grp2),
    .ctrl_q(route_q), .hit(fiq_hit));

  always_comb begin
    case (sel)
      RS_STAT0:         bus_rdata = stat0;
      RS_STAT1:         bus_rdata = g1_pend;
      RS_STAT2:         bus_rdata = g2_pend;
      RS_ROUTE:         bus_rdata = {24'h0, route_q};
      RS_SET0, RS_CLR0: bus_rdata = {{(32-PRIM_W){1'b0}}, mask0};
      RS_SET1, RS_CLR1: bus_rdata = mask1;
      RS_SET2, RS_CLR2: bus_rdata = mask2;
      default:          bus_rdata = '0;
    endcase
  end

  always_comb begin
    irq_d = |stat0;
    fiq_d = fiq_hit;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  AST_SC_NO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_ns)
    ((g1_pend & ~SC1_SET) == '0) |-> !stat0[PRIM_W]); // R5
  AST_SC_MIRROR: assert property (@(posedge clk) disable iff (!rst_ns)
    g1_pend[7] |-> stat0[PRIM_W+2]); // R6
  AST_SUMMARY_IRQ: assert property (@(posedge clk) disable iff (!rst_ns)
    (sum1 || sum2) |=> irq_o); // R8
  AST_FIQ_OFF: assert property (@(posedge clk) disable iff (!rst_ns)
    !route_q[7] |=> !fiq_o); // R9
  AST_FIQ_UNUSED: assert property (@(posedge clk) disable iff (!rst_ns)
    (route_q[RIDX_W-1:0] >= ROUTE_N) |=> !fiq_o); // R11
endmodule

// File: tb/irqc_tribank_bench.sv
module irqc_tribank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  src_prim;
  logic [31:0] src_grp1, src_grp2;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int sc1_list [5] = '{7, 9, 10, 18, 19};
  int sc2_list [6] = '{21, 22, 23, 24, 25, 30};

  always #(CLK_P/2) clk = ~clk;

  irqc_tribank u_irqc_tribank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_prim(src_prim),
    .src_grp1(src_grp1), .src_grp2(src_grp2), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    src_prim = '0; src_grp1 = '0; src_grp2 = '0;
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h0C, 32'h0);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 6'h24; a += 4) begin
      rd(a[5:0], v);
      chk("R1 register zero", v, 32'h0);
    end
    chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    chk("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] v;
    wr(6'h10, 32'h0000_00F0);
    wr(6'h10, 32'h0000_0F00);
    rd(6'h10, v); chk("R2 set accumulates", v, 32'h0000_0FF0);
    wr(6'h10, 32'h0);
    rd(6'h10, v); chk("R2 zero write no change", v, 32'h0000_0FF0);
    wr(6'h1C, 32'h0000_00F0);
    rd(6'h1C, v); chk("R2 clear word reads mask", v, 32'h0000_0F00);
    wr(6'h14, 32'h8000_0001);
    rd(6'h20, v); chk("R2 group two mask", v, 32'h8000_0001);
    wr(6'h18, 32'h0000_00A5);
    wr(6'h24, 32'h0000_0005);
    rd(6'h18, v); chk("R2 primary mask", v, 32'h0000_00A0);
    clear_all();
  endtask

  task automatic t_pend();
    logic [31:0] v;
    src_grp1 = 32'hFFFF_FFFF; src_grp2 = 32'h5555_AAAA; src_prim = 8'hFF;
    wr(6'h10, 32'h0000_0F00);
    wr(6'h14, 32'hFFFF_0000);
    wr(6'h18, 32'h0000_003C);
    rd(6'h04, v); chk("R3 group one status", v, 32'h0000_0F00);
    rd(6'h08, v); chk("R3 group two status", v, 32'h5555_0000);
    rd(6'h00, v); chk("R4 primary low bits", v & 32'hFF, 32'h0000_003C);
    clear_all();
  endtask

  task automatic t_shortcuts();
    logic [31:0] v;
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    foreach (sc1_list[k]) begin
      src_grp1 = 32'h1 << sc1_list[k];
      rd(6'h00, v); chk("R6 group one shortcut bit, R5 no summary", v, 32'h1 << (10 + k));
      rd(6'h04, v); chk("R6 group one status also set", v, 32'h1 << sc1_list[k]);
    end
    src_grp1 = '0;
    foreach (sc2_list[k]) begin
      src_grp2 = 32'h1 << sc2_list[k];
      rd(6'h00, v); chk("R6 group two shortcut bit, R5 no summary", v, 32'h1 << (15 + k));
    end
    src_grp2 = 32'h0000_0008;
    rd(6'h00, v); chk("R5 group two summary", v, 32'h0000_0200);
    src_grp2 = '0;
    src_grp1 = 32'h0000_0088;
    rd(6'h00, v); chk("R5 summary plus shortcut", v, 32'h0000_0500);
    wr(6'h1C, 32'h0000_0008);
    rd(6'h00, v); chk("R5 masked ordinary source drops summary", v, 32'h0000_0400);
    clear_all();
  endtask

  task automatic t_prim_ignores_high();
    logic [31:0] v;
    wr(6'h18, 32'hFFFF_FF00);
    rd(6'h18, v); chk("R7 high set bits ignored", v, 32'h0);
    src_grp1 = 32'h0000_0080;
    rd(6'h00, v); chk("R7 primary set cannot unmask shortcut", v, 32'h0);
    wr(6'h10, 32'h0000_0080);
    wr(6'h24, 32'hFFFF_FF00);
    rd(6'h00, v); chk("R7 primary clear cannot mask shortcut", v, 32'h0000_0400);
    clear_all();
  endtask

  task automatic t_irq();
    src_grp1 = 32'h0000_0004;
    settle();
    chk("R8 masked source no irq", {31'h0, irq_o}, 32'h0);
    wr(6'h10, 32'h0000_0004);
    settle();
    chk("R8 unmaskable summary raises irq", {31'h0, irq_o}, 32'h1);
    src_grp1 = '0;
    settle();
    chk("R8 irq drops", {31'h0, irq_o}, 32'h0);
    src_prim = 8'h40;
    wr(6'h18, 32'h0000_0040);
    settle();
    chk("R8 primary line irq", {31'h0, irq_o}, 32'h1);
    clear_all();
  endtask

  task automatic t_fiq();
    logic [31:0] v;
    wr(6'h0C, 32'hFFFF_FF85);
    rd(6'h0C, v); chk("R9 route readback", v, 32'h0000_0085);
    src_grp1 = 32'h0000_0020;
    settle();
    chk("R9 index 5 fiq", {31'h0, fiq_o}, 32'h1);
    chk("R9 fiq ignores mask, irq low", {31'h0, irq_o}, 32'h0);
    wr(6'h10, 32'h0000_0020);
    settle();
    chk("R10 both outputs irq", {31'h0, irq_o}, 32'h1);
    chk("R10 both outputs fiq", {31'h0, fiq_o}, 32'h1);
    wr(6'h0C, 32'h0000_0005);
    settle();
    chk("R9 disabled fiq low", {31'h0, fiq_o}, 32'h0);
    src_grp1 = '0; src_grp2 = 32'h4000_0000;
    wr(6'h0C, 32'h0000_00BE);
    settle();
    chk("R9 index 62 group two bit 30", {31'h0, fiq_o}, 32'h1);
    src_grp2 = '0; src_prim = 8'h08;
    wr(6'h0C, 32'h0000_00C3);
    settle();
    chk("R9 index 67 primary line 3", {31'h0, fiq_o}, 32'h1);
    src_prim = 8'hFF; src_grp1 = 32'hFFFF_FFFF; src_grp2 = 32'hFFFF_FFFF;
    wr(6'h0C, 32'h0000_00E4);
    settle();
    chk("R11 index 100 selects nothing", {31'h0, fiq_o}, 32'h0);
    wr(6'h0C, 32'h0000_00C8);
    settle();
    chk("R11 index 72 selects nothing", {31'h0, fiq_o}, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    src_prim = '0; src_grp1 = '0; src_grp2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mask_rw();
    t_pend();
    t_shortcuts();
    t_prim_ignores_high();
    t_irq();
    t_fiq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule